// File: doc/BRIEF.md
# Configurable sum-of-products logic array

This block is the logic core of a small programmable device. Twelve dedicated inputs and ten feedback signals each enter the array in true and inverted form, giving 44 input lines. There are 132 product terms. Each one is an AND over whichever of those lines its configuration row selects. 120 of the terms are gathered by a fixed OR plane into ten sums. Output 0 owns the first group of rows, and the group sizes rise in pairs from 8 to 16. The remaining twelve terms leave the block unsummed: one enable term per output, one global preset term and one global clear term.

The configuration is a store of 132 rows of 44 bits. It is written one row per clock edge through an address and data port while the write enable is high. Once it is loaded, every output follows the inputs combinationally, with no clock in the path. A synchronous reset sets every bit to connected, so all terms read false until real rows are written. Output registers, pin drivers and nonvolatile storage belong to the surrounding design.

Top module: `sop_array`

## Requirements
- R1: After reset every configuration bit is 1, so for any input pattern all ten sums, all ten enable terms, the preset term and the clear term read 0.
- R2: Input line 2*s carries signal s and line 2*s+1 carries its inverse. Signals 0 to 11 are `ded_in[0]` to `ded_in[11]`, and signals 12 to 21 are `fb_in[0]` to `fb_in[9]`.
- R3: With `cfg_we` high and `cfg_addr` below 132, `cfg_data` replaces configuration row `cfg_addr` at the rising clock edge. Bit j = 1 connects line j to that row's term. The new row affects the outputs only after that edge.
- R4: A clock edge with `cfg_we` low, or with `cfg_addr` of 132 or more, changes no configuration row.
- R5: Each product term is the AND of every line connected in its row.
- R6: A row with no bit set gives a term that is always 1.
- R7: A row that connects both line 2*s and line 2*s+1 gives a term that is always 0.
- R8: `sum_out[k]` is the OR of a consecutive run of rows. Runs are taken in output order starting at row 0, with sizes 8, 8, 10, 10, 12, 12, 14, 14, 16, 16 (rows 0 to 119).
- R9: Row 120+k drives `oe_term[k]`, row 130 drives `preset_term` and row 131 drives `clear_term`.
- R10: All outputs respond to changes of `ded_in` and `fb_in` within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | 8 | Row index to write |
| cfg_data | input | 44 | Row contents, one bit per input line |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Per-output enable product terms |
| preset_term | output | 1 | Global preset product term |
| clear_term | output | 1 | Global clear product term |

## Verification
A walk sets one row at a time to empty while every other row stays fully connected. Only that row's term is then true, so each row must raise exactly its own output bit, and this shows the group boundaries and the position of the twelve special rows. Directed rows separate a true line from its inverted line and a dedicated input from a feedback input, and they cover a contradictory pair and an empty row. Sparse random rows with one to three connections, driven by random inputs, give terms that are true at a useful rate, so the AND and OR planes are compared against a model under many mixed patterns. Writes to out-of-range addresses and cycles with the enable low must leave every output as it was.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int NUM_DED       = 12;
    localparam int NUM_FB        = 10;
    localparam int NUM_SIG       = NUM_DED + NUM_FB;
    localparam int NUM_LINES     = 2 * NUM_SIG;
    localparam int NUM_OUT       = 10;
    localparam int GRP_MIN       = 8;
    localparam int GRP_STEP      = 2;
    localparam int NUM_SUM_ROWS  = 120;
    localparam int ROW_OE_BASE   = NUM_SUM_ROWS;
    localparam int ROW_PRESET    = ROW_OE_BASE + NUM_OUT;
    localparam int ROW_CLEAR     = ROW_PRESET + 1;
    localparam int NUM_ROWS      = ROW_CLEAR + 1;
    localparam int ADDR_W        = $clog2(NUM_ROWS);

    typedef logic [NUM_LINES-1:0] row_t;
    typedef logic [NUM_ROWS-1:0][NUM_LINES-1:0] cfg_plane_t;
    typedef logic [NUM_ROWS-1:0] term_vec_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        row_t              data;
    } cfg_wr_t;

    typedef struct packed {
        logic [NUM_OUT-1:0] sum;
        logic [NUM_OUT-1:0] oe;
        logic               preset;
        logic               clear;
    } plane_out_t;

    // Rows owned by output k: sizes rise in pairs.
    function automatic int grp_size(int k);
        return GRP_MIN + GRP_STEP * (k / 2);
    endfunction

    function automatic int grp_base(int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) acc += grp_size(j);
        return acc;
    endfunction

    // True when a row selects both polarities of any one signal.
    function automatic logic has_pair(row_t r);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < NUM_SIG; s++) hit |= r[2*s] & r[2*s+1];
        return hit;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
    import sop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_wr_t    wr_i,
    output cfg_plane_t cfg_o
);

    cfg_plane_t cfg_q;
    logic       addr_ok;

    assign addr_ok = (int'(wr_i.addr) < NUM_ROWS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '1;
        end else if (wr_i.we && addr_ok) begin
            cfg_q[wr_i.addr] <= wr_i.data;
        end
    end

    assign cfg_o = cfg_q;

    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i.we && addr_ok) |=> (cfg_q[$past(wr_i.addr)] == $past(wr_i.data)));

    // R4
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_i.we || !addr_ok) |=> $stable(cfg_q));

endmodule

// File: rtl/sop_line_gen.sv
module sop_line_gen
    import sop_pkg::*;
(
    input  logic [NUM_DED-1:0] ded_i,
    input  logic [NUM_FB-1:0]  fb_i,
    output row_t               lines_o
);

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        logic sig;
        if (s < NUM_DED) begin : g_ded
            assign sig = ded_i[s];
        end else begin : g_fb
            assign sig = fb_i[s - NUM_DED];
        end
        assign lines_o[2*s]   = sig;
        assign lines_o[2*s+1] = ~sig;
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_plane_t cfg_i,
    input  row_t       lines_i,
    output term_vec_t  term_o
);

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        // Unconnected lines read as 1, so an empty row is true.
        assign term_o[r] = &(~cfg_i[r] | lines_i);

        // R7
        pair_false_chk: assert property (@(posedge clk) disable iff (rst)
            has_pair(cfg_i[r]) |-> !term_o[r]);

        // R6
        empty_true_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_i[r] == '0) |-> term_o[r]);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
(
    input  term_vec_t  term_i,
    output plane_out_t out_o
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_sum
        localparam int BASE = grp_base(k);
        localparam int SIZE = grp_size(k);
        assign out_o.sum[k] = |term_i[BASE +: SIZE];
    end

    assign out_o.oe     = term_i[ROW_OE_BASE +: NUM_OUT];
    assign out_o.preset = term_i[ROW_PRESET];
    assign out_o.clear  = term_i[ROW_CLEAR];

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [NUM_LINES-1:0] cfg_data,
    input  logic [NUM_DED-1:0]   ded_in,
    input  logic [NUM_FB-1:0]    fb_in,
    output logic [NUM_OUT-1:0]   sum_out,
    output logic [NUM_OUT-1:0]   oe_term,
    output logic                 preset_term,
    output logic                 clear_term
);

    cfg_wr_t    wr;
    cfg_plane_t cfg;
    row_t       lines;
    term_vec_t  terms;
    plane_out_t pout;

    assign wr.we   = cfg_we;
    assign wr.addr = cfg_addr;
    assign wr.data = cfg_data;

    sop_cfg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr),
        .cfg_o (cfg)
    );

    sop_line_gen u_lines (
        .ded_i   (ded_in),
        .fb_i    (fb_in),
        .lines_o (lines)
    );

    sop_and_plane u_and (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg),
        .lines_i (lines),
        .term_o  (terms)
    );

    sop_or_plane u_or (
        .term_i (terms),
        .out_o  (pout)
    );

    assign sum_out     = pout.sum;
    assign oe_term     = pout.oe;
    assign preset_term = pout.preset;
    assign clear_term  = pout.clear;

endmodule

// File: tb/sop_array_test.sv
module sop_array_test;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 132;
    localparam int LINES = 44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [43:0] cfg_data = '0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_term;
    logic        preset_term, clear_term;

    logic [43:0] shadow [ROWS];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    sop_array uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .ded_in(ded_in), .fb_in(fb_in),
        .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [21:0] model(logic [11:0] d, logic [9:0] f);
        logic [43:0]    ln;
        logic [ROWS-1:0] t;
        logic [9:0]     s;
        int             base;
        for (int i = 0; i < 22; i++) begin
            logic v;
            v = (i < 12) ? d[i] : f[i-12];
            ln[2*i]   = v;
            ln[2*i+1] = ~v;
        end
        for (int r = 0; r < ROWS; r++) begin
            t[r] = 1'b1;
            for (int j = 0; j < LINES; j++)
                if (shadow[r][j] && !ln[j]) t[r] = 1'b0;
        end
        base = 0;
        for (int k = 0; k < 10; k++) begin
            int sz;
            sz = 8 + 2 * (k / 2);
            s[k] = 1'b0;
            for (int i = 0; i < sz; i++) s[k] |= t[base + i];
            base += sz;
        end
        return {s, t[129:120], t[130], t[131]};
    endfunction

    function automatic logic [21:0] observed();
        return {sum_out, oe_term, preset_term, clear_term};
    endfunction

    task automatic chk(string tag, logic [21:0] act, logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_row(logic [7:0] a, logic [43:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(posedge clk);
        if (int'(a) < ROWS) shadow[a] = d;
        #1 cfg_we = 1'b0;
    endtask

    task automatic drive_check(string tag, logic [11:0] d, logic [9:0] f);
        @(negedge clk);
        ded_in = d; fb_in = f;
        #2 chk(tag, observed(), model(d, f));
    endtask

    function automatic logic [43:0] rand_row();
        logic [43:0] r;
        int mode;
        mode = $urandom % 5;
        if (mode == 0) return '0;
        if (mode == 1) return '1;
        r = '0;
        for (int i = 0; i < mode - 1; i++) r[$urandom % LINES] = 1'b1;
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17C0DE);
        for (int r = 0; r < ROWS; r++) shadow[r] = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state gives all terms false
        for (int i = 0; i < 4; i++) begin
            logic [11:0] d;
            logic [9:0]  f;
            d = 12'($urandom); f = 10'($urandom);
            @(negedge clk); ded_in = d; fb_in = f;
            #2 chk("R1", observed(), 22'h0);
        end

        // R3: write not visible before the edge, visible after
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'd0; cfg_data = '0;
        #2 chk("R3 pre-edge", observed(), 22'h0);
        @(posedge clk); shadow[0] = '0;
        #1 cfg_we = 1'b0;
        #2 chk("R3 post-edge", observed(), {10'b1, 12'h0});
        // R6: empty row true under other inputs
        drive_check("R6", 12'hFFF, 10'h3FF);

        // R7: line 0 and line 1 together
        write_row(8'd0, 44'h3);
        drive_check("R7", 12'h000, 10'h000);
        drive_check("R7", 12'h001, 10'h155);

        // R4: out-of-range address and enable low change nothing
        write_row(8'd200, '0);
        write_row(8'd132, '0);
        drive_check("R4 out-of-range", 12'hABC, 10'h2AA);
        @(negedge clk); cfg_addr = 8'd5; cfg_data = '0; cfg_we = 1'b0;
        @(posedge clk);
        drive_check("R4 enable low", 12'h123, 10'h0F0);

        // R8 R9: walk an empty row through every position
        write_row(8'd0, '1);
        for (int r = 0; r < ROWS; r++) begin
            write_row(8'(r), '0);
            if (r < 120)      drive_check("R8 walk", 12'h5A5, 10'h1C3);
            else              drive_check("R9 walk", 12'h5A5, 10'h1C3);
            write_row(8'(r), '1);
        end

        // R2 R10: polarity and source of lines, no clock between change and check
        write_row(8'd8, 44'h1);                   // ded_in[0] true
        write_row(8'd120, 44'h1 << 25);           // fb_in[0] inverted
        write_row(8'd130, 44'h1 << 23);           // ded_in[11] inverted
        write_row(8'd131, 44'h1 << 42);           // fb_in[9] true
        @(negedge clk);
        ded_in = 12'h001; fb_in = 10'h000;
        #1 chk("R2", observed(), model(12'h001, 10'h000));
        ded_in = 12'h800; fb_in = 10'h201;
        #1 chk("R10", observed(), model(12'h800, 10'h201));
        ded_in = 12'h000; fb_in = 10'h200;
        #1 chk("R10", observed(), model(12'h000, 10'h200));

        // R5: sparse random rows, random inputs
        for (int round = 0; round < 25; round++) begin
            for (int r = 0; r < ROWS; r++) write_row(8'(r), rand_row());
            for (int p = 0; p < 16; p++)
                drive_check("R5", 12'($urandom), 10'($urandom));
        end

        finish_run();
    end

endmodule